// File: doc/BRIEF.md
# Scanline DMA Slot Scheduler

This block is the timing core of a video DMA controller. It counts machine cycles across a 114-cycle scanline and counts scanlines across a frame. The frame is 262 lines long for NTSC and 312 lines long for PAL. In every cycle it names one owner of the memory bus through a one-hot grant. The possible owners are a display-list instruction fetch, an operand fetch, a player fetch, a missile fetch, a screen-data fetch, a memory refresh, or the CPU. A halt output stops the CPU in any cycle the video side takes.

The slot map is fixed, but each slot is owned only under a condition. Cycle 0 holds the list-instruction fetch, or the missile fetch when no list fetch is due. When cycle 0 went to the list fetch, the missile fetch moves to cycle 112. Cycles 1 to 4 carry player data and cycles 5 and 6 carry operand bytes. Cycles 7 to 9 always belong to the CPU. The playfield window lies between cycle 10 and cycle 105; its first cycle, last cycle and fetch rate are inputs. Nine refresh requests arise on every line. A request that meets a screen fetch waits for the next free cycle, and any request still waiting after cycle 105 is discarded.

Video DMA happens only on the 240 display lines. The blank lines around them carry refresh alone, and vertical sync covers the last three lines of the frame. Address generation and the data path belong to other blocks.

Top module: `dma_slot_sched`

## Requirements
- R1: `hPos` starts at 0, counts up by one every clock, and returns to 0 after 113. `vLine` increments in the clock where `hPos` wraps.
- R2: `vLine` returns to 0 after line 261 when `palMode` is 0, and after line 311 when `palMode` is 1.
- R3: `vBlank` is low exactly on lines 8 to 247. `vSync` is high exactly on the last three lines of the frame.
- R4: `grant` is one-hot with bit 0 CPU, bit 1 list fetch, bit 2 operand, bit 3 player, bit 4 missile, bit 5 screen and bit 6 refresh. `cpuHalt` is high exactly when bit 0 is low.
- R5: On a display line, cycle 0 goes to the list fetch when `listDue` is high. Otherwise it goes to the missile fetch when `missileEn` is high, and otherwise to the CPU.
- R6: On a display line, cycles 1 to 4 go to player fetches when `playerEn` is high, and cycles 5 and 6 go to operand fetches when `operandDue` is high. Cycles 7 to 9 always go to the CPU.
- R7: On a display line, cycle 112 goes to the missile fetch when `missileEn` is high and cycle 0 of the same line went to the list fetch.
- R8: On a display line, screen fetches occur only between max(`pfFirst`,10) and min(`pfLast`,105). `pfMode` selects the rate, counted from `pfFirst`: 0 gives none, 1 every cycle, 2 every second cycle and 3 every fourth cycle.
- R9: One refresh request arises at each of cycles 25, 29, ..., 57. A request is served in its own cycle unless a screen fetch holds that cycle. Waiting requests are served one per cycle in the next cycles without a screen fetch. Requests not served by cycle 105 are dropped.
- R10: Every blank line gives exactly 105 CPU cycles and 9 refresh cycles, with no video DMA.
- R11: During reset, `hPos` and `vLine` are 0, `vBlank` is 1, `vSync` is 0 and `grant` selects the CPU.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine-cycle clock |
| rstN | input | 1 | Asynchronous reset, active low |
| palMode | input | 1 | 1 selects the 312-line frame, 0 the 262-line frame |
| listDue | input | 1 | A list-instruction fetch is due on this line |
| operandDue | input | 1 | The current instruction needs two operand bytes |
| playerEn | input | 1 | Player DMA enabled |
| missileEn | input | 1 | Missile DMA enabled |
| pfMode | input | 2 | Screen fetch rate: 0 off, 1 every cycle, 2 every second, 3 every fourth |
| pfFirst | input | 7 | First playfield fetch cycle requested |
| pfLast | input | 7 | Last playfield fetch cycle requested |
| grant | output | 7 | One-hot bus owner for the current cycle |
| cpuHalt | output | 1 | CPU held off this cycle |
| hPos | output | 7 | Cycle within the line |
| vLine | output | 9 | Line within the frame |
| vSync | output | 1 | Vertical sync region |
| vBlank | output | 1 | Outside the display lines |

## Verification
The bench uses the default parameters: a 114-cycle line, 240 display lines after 8 top blank lines, three sync lines, and refresh every 4 cycles from cycle 25. These values let one NTSC frame and one PAL frame fit in a single run, so both wrap points and the change of standard at a frame boundary are exercised. The directed lines place screen fetches on the refresh cycles. With the full-width playfield every refresh is dropped, with a rate of two every refresh is deferred, and with a rate of four between refreshes none is disturbed.

// File: rtl/dss_pkg.sv
package dss_pkg;

  // grant bit positions
  localparam int G_CPU     = 0;
  localparam int G_LIST    = 1;
  localparam int G_OPERAND = 2;
  localparam int G_PLAYER  = 3;
  localparam int G_MISSILE = 4;
  localparam int G_SCREEN  = 5;
  localparam int G_REFRESH = 6;
  localparam int G_NUM     = 7;

  // position strobes passed from the counter datapath to the slot control
  typedef struct packed {
    logic displayLine;
    logic slotZero;
    logic playerSlot;
    logic operandSlot;
    logic missileLate;
    logic screenSlot;
    logic refreshTick;
    logic refreshOpen;
    logic refreshCutoff;
  } slotStrobes_t;

endpackage

// File: rtl/dss_datapath.sv
module dss_datapath
  import dss_pkg::*;
#(
  parameter int LINE_CYCLES   = 114,
  parameter int DISPLAY_LINES = 240,
  parameter int TOP_BLANK     = 8,
  parameter int NTSC_EXTRA    = 22,
  parameter int PAL_EXTRA     = 72,
  parameter int VSYNC_LINES   = 3,
  parameter int PF_EARLIEST   = 10,
  parameter int PF_LATEST     = 105,
  parameter int MISSILE_LATE  = 112,
  parameter int PLAYER_FIRST  = 1,
  parameter int PLAYER_SLOTS  = 4,
  parameter int OPERAND_FIRST = 5,
  parameter int OPERAND_SLOTS = 2,
  parameter int REFRESH_FIRST = 25,
  parameter int REFRESH_GAP   = 4,
  parameter int REFRESH_COUNT = 9,
  parameter int H_W           = 7,
  parameter int V_W           = 9
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           palMode,
  input  logic [1:0]     pfMode,
  input  logic [H_W-1:0] pfFirst,
  input  logic [H_W-1:0] pfLast,
  output logic [H_W-1:0] hPos,
  output logic [V_W-1:0] vLine,
  output logic           vSync,
  output logic           vBlank,
  output slotStrobes_t   strobes
);

  localparam int NTSC_LINES = DISPLAY_LINES + NTSC_EXTRA;
  localparam int PAL_LINES  = DISPLAY_LINES + PAL_EXTRA;
  localparam logic [H_W-1:0] LAST_H       = H_W'(LINE_CYCLES - 1);
  localparam logic [H_W-1:0] PF_LO_H      = H_W'(PF_EARLIEST);
  localparam logic [H_W-1:0] PF_HI_H      = H_W'(PF_LATEST);
  localparam logic [H_W-1:0] MISSILE_H    = H_W'(MISSILE_LATE);
  localparam logic [H_W-1:0] PLAYER_LO_H  = H_W'(PLAYER_FIRST);
  localparam logic [H_W-1:0] PLAYER_END_H = H_W'(PLAYER_FIRST + PLAYER_SLOTS);
  localparam logic [H_W-1:0] OPND_LO_H    = H_W'(OPERAND_FIRST);
  localparam logic [H_W-1:0] OPND_END_H   = H_W'(OPERAND_FIRST + OPERAND_SLOTS);
  localparam logic [V_W-1:0] NTSC_LAST_V  = V_W'(NTSC_LINES - 1);
  localparam logic [V_W-1:0] PAL_LAST_V   = V_W'(PAL_LINES - 1);
  localparam logic [V_W-1:0] DISP_LO_V    = V_W'(TOP_BLANK);
  localparam logic [V_W-1:0] DISP_END_V   = V_W'(TOP_BLANK + DISPLAY_LINES);
  localparam logic [V_W-1:0] VSYNC_V      = V_W'(VSYNC_LINES);

  logic [H_W-1:0] hCount;
  logic [V_W-1:0] vCount;
  logic [V_W-1:0] lastLine;
  logic           lineWrap;

  assign lastLine = palMode ? PAL_LAST_V : NTSC_LAST_V;
  assign lineWrap = (hCount == LAST_H);

  // horizontal and vertical counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCount <= '0;
      vCount <= '0;
    end else begin
      hCount <= lineWrap ? '0 : hCount + 1'b1;
      if (lineWrap) begin
        vCount <= (vCount >= lastLine) ? '0 : vCount + 1'b1;
      end
    end
  end

  logic displayLine;
  assign displayLine = (vCount >= DISP_LO_V) && (vCount < DISP_END_V);

  // refresh request cycles, one comparator per request
  logic [REFRESH_COUNT-1:0] tickHits;
  for (genvar k = 0; k < REFRESH_COUNT; k++) begin : g_refTick
    assign tickHits[k] = (hCount == H_W'(REFRESH_FIRST + k * REFRESH_GAP));
  end

  // playfield window and fetch rate
  logic [H_W-1:0] winLo, winHi, winOffset;
  logic [1:0]     rateMask;
  logic           inWindow;

  assign winLo     = (pfFirst > PF_LO_H) ? pfFirst : PF_LO_H;
  assign winHi     = (pfLast < PF_HI_H) ? pfLast : PF_HI_H;
  assign winOffset = hCount - pfFirst;
  assign inWindow  = (hCount >= winLo) && (hCount <= winHi);

  always_comb begin
    unique case (pfMode)
      2'd1:    rateMask = 2'b00;
      2'd2:    rateMask = 2'b01;
      default: rateMask = 2'b11;
    endcase
  end

  always_comb begin
    strobes               = '0;
    strobes.displayLine   = displayLine;
    strobes.slotZero      = (hCount == '0);
    strobes.playerSlot    = (hCount >= PLAYER_LO_H) && (hCount < PLAYER_END_H);
    strobes.operandSlot   = (hCount >= OPND_LO_H) && (hCount < OPND_END_H);
    strobes.missileLate   = (hCount == MISSILE_H);
    strobes.screenSlot    = (pfMode != 2'd0) && inWindow &&
                            ((winOffset[1:0] & rateMask) == 2'b00);
    strobes.refreshTick   = |tickHits;
    strobes.refreshOpen   = (hCount <= PF_HI_H);
    strobes.refreshCutoff = (hCount == PF_HI_H);
  end

  assign hPos   = hCount;
  assign vLine  = vCount;
  assign vBlank = !displayLine;
  assign vSync  = (vCount > lastLine - VSYNC_V);

endmodule

// File: rtl/dss_ctrl.sv
module dss_ctrl
  import dss_pkg::*;
#(
  parameter int REFRESH_COUNT = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  slotStrobes_t     strobes,
  input  logic             listDue,
  input  logic             operandDue,
  input  logic             playerEn,
  input  logic             missileEn,
  output logic [G_NUM-1:0] grant,
  output logic             cpuHalt
);

  localparam int PEND_W = $clog2(REFRESH_COUNT + 1);

  logic [PEND_W-1:0] pending;
  logic              listTook;
  logic              refreshWanted;
  logic              refreshGrant;
  logic [G_NUM-1:0]  videoGrant;

  // video slots, in fixed priority
  always_comb begin
    videoGrant = '0;
    if (strobes.displayLine) begin
      if (strobes.slotZero && listDue)
        videoGrant[G_LIST] = 1'b1;
      else if (strobes.slotZero && missileEn)
        videoGrant[G_MISSILE] = 1'b1;
      else if (strobes.playerSlot && playerEn)
        videoGrant[G_PLAYER] = 1'b1;
      else if (strobes.operandSlot && operandDue)
        videoGrant[G_OPERAND] = 1'b1;
      else if (strobes.missileLate && missileEn && listTook)
        videoGrant[G_MISSILE] = 1'b1;
      else if (strobes.screenSlot)
        videoGrant[G_SCREEN] = 1'b1;
    end
  end

  assign refreshWanted = (pending != '0) || strobes.refreshTick;
  assign refreshGrant  = refreshWanted && strobes.refreshOpen && (videoGrant == '0);

  always_comb begin
    grant = videoGrant;
    if (videoGrant == '0) begin
      if (refreshGrant) grant[G_REFRESH] = 1'b1;
      else              grant[G_CPU]     = 1'b1;
    end
  end

  assign cpuHalt = !grant[G_CPU];

  // refresh backlog and list-fetch memory for the late missile slot
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending  <= '0;
      listTook <= 1'b0;
    end else begin
      if (strobes.refreshCutoff)
        pending <= '0;
      else
        pending <= pending + PEND_W'(strobes.refreshTick) - PEND_W'(refreshGrant);
      if (strobes.slotZero)
        listTook <= strobes.displayLine && listDue;
    end
  end

endmodule

// File: rtl/dma_slot_sched.sv
module dma_slot_sched
  import dss_pkg::*;
#(
  parameter int LINE_CYCLES   = 114,
  parameter int DISPLAY_LINES = 240,
  parameter int TOP_BLANK     = 8,
  parameter int NTSC_EXTRA    = 22,
  parameter int PAL_EXTRA     = 72,
  parameter int VSYNC_LINES   = 3,
  parameter int PF_EARLIEST   = 10,
  parameter int PF_LATEST     = 105,
  parameter int MISSILE_LATE  = 112,
  parameter int PLAYER_FIRST  = 1,
  parameter int PLAYER_SLOTS  = 4,
  parameter int OPERAND_FIRST = 5,
  parameter int OPERAND_SLOTS = 2,
  parameter int REFRESH_FIRST = 25,
  parameter int REFRESH_GAP   = 4,
  parameter int REFRESH_COUNT = 9,
  localparam int H_W = $clog2(LINE_CYCLES),
  localparam int V_W = $clog2(DISPLAY_LINES + ((PAL_EXTRA > NTSC_EXTRA) ? PAL_EXTRA : NTSC_EXTRA))
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           palMode,
  input  logic           listDue,
  input  logic           operandDue,
  input  logic           playerEn,
  input  logic           missileEn,
  input  logic [1:0]     pfMode,
  input  logic [H_W-1:0] pfFirst,
  input  logic [H_W-1:0] pfLast,
  output logic [6:0]     grant,
  output logic           cpuHalt,
  output logic [H_W-1:0] hPos,
  output logic [V_W-1:0] vLine,
  output logic           vSync,
  output logic           vBlank
);

  slotStrobes_t strobes;

  dss_datapath #(
    .LINE_CYCLES  (LINE_CYCLES),
    .DISPLAY_LINES(DISPLAY_LINES),
    .TOP_BLANK    (TOP_BLANK),
    .NTSC_EXTRA   (NTSC_EXTRA),
    .PAL_EXTRA    (PAL_EXTRA),
    .VSYNC_LINES  (VSYNC_LINES),
    .PF_EARLIEST  (PF_EARLIEST),
    .PF_LATEST    (PF_LATEST),
    .MISSILE_LATE (MISSILE_LATE),
    .PLAYER_FIRST (PLAYER_FIRST),
    .PLAYER_SLOTS (PLAYER_SLOTS),
    .OPERAND_FIRST(OPERAND_FIRST),
    .OPERAND_SLOTS(OPERAND_SLOTS),
    .REFRESH_FIRST(REFRESH_FIRST),
    .REFRESH_GAP  (REFRESH_GAP),
    .REFRESH_COUNT(REFRESH_COUNT),
    .H_W          (H_W),
    .V_W          (V_W)
  ) u_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .palMode(palMode),
    .pfMode (pfMode),
    .pfFirst(pfFirst),
    .pfLast (pfLast),
    .hPos   (hPos),
    .vLine  (vLine),
    .vSync  (vSync),
    .vBlank (vBlank),
    .strobes(strobes)
  );

  dss_ctrl #(
    .REFRESH_COUNT(REFRESH_COUNT)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .listDue   (listDue),
    .operandDue(operandDue),
    .playerEn  (playerEn),
    .missileEn (missileEn),
    .grant     (grant),
    .cpuHalt   (cpuHalt)
  );

endmodule

// File: rtl/dss_checker.sv
module dss_checker #(
  parameter int H_W          = 7,
  parameter int V_W          = 9,
  parameter int LAST_CYCLE   = 113,
  parameter int PF_EARLIEST  = 10,
  parameter int PF_LATEST    = 105,
  parameter int REFRESH_FIRST = 25
) (
  input logic           clk,
  input logic           rstN,
  input logic [6:0]     grant,
  input logic           cpuHalt,
  input logic [H_W-1:0] hPos,
  input logic [V_W-1:0] vLine,
  input logic           vSync,
  input logic           vBlank
);

  // R4
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(grant) == 1);

  // R4
  halt_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuHalt == !grant[0]);

  // R1
  hpos_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hPos != H_W'(LAST_CYCLE)) |=> (hPos == $past(hPos) + 1'b1));

  // R1
  hpos_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hPos == H_W'(LAST_CYCLE)) |=> (hPos == '0));

  // R6
  cpu_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hPos >= H_W'(7) && hPos <= H_W'(9)) |-> (grant == 7'b0000001));

  // R8
  screen_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    grant[5] |-> (hPos >= H_W'(PF_EARLIEST) && hPos <= H_W'(PF_LATEST)));

  // R9
  refresh_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    grant[6] |-> (hPos >= H_W'(REFRESH_FIRST) && hPos <= H_W'(PF_LATEST)));

  // R3
  vsync_blank_chk: assert property (@(posedge clk) disable iff (!rstN)
    vSync |-> vBlank);

  // R10
  blank_no_video_chk: assert property (@(posedge clk) disable iff (!rstN)
    vBlank |-> (grant[5:1] == '0));

  // R2
  vline_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hPos != H_W'(LAST_CYCLE)) |=> $stable(vLine));

endmodule

bind dma_slot_sched dss_checker u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .grant  (grant),
  .cpuHalt(cpuHalt),
  .hPos   (hPos),
  .vLine  (vLine),
  .vSync  (vSync),
  .vBlank (vBlank)
);

// File: tb/sim_dma_slot_sched.sv
`timescale 1ns/1ps
module sim_dma_slot_sched;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       palMode = 1'b0;
  logic       listDue = 1'b0, operandDue = 1'b0, playerEn = 1'b0, missileEn = 1'b0;
  logic [1:0] pfMode = 2'd0;
  logic [6:0] pfFirst = 7'd0, pfLast = 7'd0;
  logic [6:0] grant;
  logic       cpuHalt;
  logic [6:0] hPos;
  logic [8:0] vLine;
  logic       vSync, vBlank;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  dma_slot_sched u0 (
    .clk(clk), .rstN(rstN), .palMode(palMode), .listDue(listDue),
    .operandDue(operandDue), .playerEn(playerEn), .missileEn(missileEn),
    .pfMode(pfMode), .pfFirst(pfFirst), .pfLast(pfLast), .grant(grant),
    .cpuHalt(cpuHalt), .hPos(hPos), .vLine(vLine), .vSync(vSync), .vBlank(vBlank)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      if (errors <= 20)
        $display("FAIL %s actual=%0d expected=%0d (line %0d cycle %0d)", tag, act, exp, vLine, hPos);
    end
  endtask

  function automatic bit isTick(int h);
    return (h >= 25) && (h <= 57) && (((h - 25) % 4) == 0);
  endfunction

  function automatic bit isScreen(int h, bit disp, int mode, int first, int last);
    int lo, hi, mask;
    lo = (first > 10) ? first : 10;
    hi = (last < 105) ? last : 105;
    mask = (mode == 1) ? 0 : ((mode == 2) ? 1 : 3);
    return disp && (mode != 0) && (h >= lo) && (h <= hi) && (((h - first) & mask) == 0);
  endfunction

  // expected owner; tag names the requirement that decides it
  function automatic logic [6:0] expGrant(int h, bit disp, bit ld, bit od, bit pe, bit me,
                                          bit took, int mode, int first, int last, int pend,
                                          output string tag);
    logic [6:0] g;
    g = '0;
    tag = "R4";
    if (disp && h == 0 && ld) begin g[1] = 1'b1; tag = "R5"; end
    else if (disp && h == 0 && me) begin g[4] = 1'b1; tag = "R5"; end
    else if (disp && h >= 1 && h <= 4 && pe) begin g[3] = 1'b1; tag = "R6"; end
    else if (disp && (h == 5 || h == 6) && od) begin g[2] = 1'b1; tag = "R6"; end
    else if (disp && h == 112 && me && took) begin g[4] = 1'b1; tag = "R7"; end
    else if (isScreen(h, disp, mode, first, last)) begin g[5] = 1'b1; tag = "R8"; end
    else if ((pend > 0 || isTick(h)) && h <= 105) begin g[6] = 1'b1; tag = "R9"; end
    else begin
      g[0] = 1'b1;
      if (h >= 7 && h <= 9) tag = "R6";
      else if (!disp) tag = "R10";
    end
    return g;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    int v, pend, cpuCnt, refCnt, total;
    bit took, disp;
    logic [6:0] eg;
    string tag;
    void'($urandom(32'd4711));
    v = 0; pend = 0; took = 0; cpuCnt = 0; refCnt = 0;

    repeat (3) @(negedge clk);
    // R11 reset state
    chk(hPos == 0, "R11 hPos", hPos, 0);
    chk(vLine == 0, "R11 vLine", vLine, 0);
    chk(vBlank == 1'b1, "R11 vBlank", vBlank, 1);
    chk(vSync == 1'b0, "R11 vSync", vSync, 0);
    chk(grant == 7'b0000001, "R11 grant", grant, 1);
    rstN = 1'b1;

    for (int line = 0; line < 262 + 312 + 3; line++) begin
      if (line == 262) palMode = 1'b1;  // switch standard at a frame boundary
      total = palMode ? 312 : 262;
      disp = (v >= 8) && (v < 248);
      // per-line stimulus: directed corner lines first, random after
      if (line == 8) begin
        listDue = 1; missileEn = 1; playerEn = 1; operandDue = 1;
        pfMode = 2'd1; pfFirst = 7'd0; pfLast = 7'd127;
      end else if (line == 9) begin
        listDue = 0; missileEn = 1; playerEn = 0; operandDue = 0;
        pfMode = 2'd2; pfFirst = 7'd25; pfLast = 7'd100;
      end else if (line == 10) begin
        listDue = 1; missileEn = 0; playerEn = 1; operandDue = 0;
        pfMode = 2'd3; pfFirst = 7'd26; pfLast = 7'd60;
      end else begin
        listDue    = 1'($urandom);
        operandDue = 1'($urandom);
        playerEn   = 1'($urandom);
        missileEn  = 1'($urandom);
        pfMode     = 2'($urandom);
        pfFirst    = 7'($urandom_range(0, 40));
        pfLast     = 7'($urandom_range(50, 127));
      end
      for (int h = 0; h < 114; h++) begin
        #1;
        eg = expGrant(h, disp, listDue, operandDue, playerEn, missileEn, took,
                      int'(pfMode), int'(pfFirst), int'(pfLast), pend, tag);
        chk(hPos == 7'(h), "R1 hPos", hPos, h);
        chk(vLine == 9'(v), "R2 vLine", vLine, v);
        chk(vBlank == !disp, "R3 vBlank", vBlank, !disp);
        chk(vSync == (v >= total - 3), "R3 vSync", vSync, (v >= total - 3));
        chk(grant == eg, tag, grant, eg);
        chk(cpuHalt == !eg[0], "R4 cpuHalt", cpuHalt, !eg[0]);
        if (!disp) begin
          cpuCnt += int'(grant[0]);
          refCnt += int'(grant[6]);
        end
        // model update for the next cycle
        if (h == 0) took = disp && listDue;
        if (h == 105) pend = 0;
        else pend = pend + int'(isTick(h)) - int'(eg[6]);
        @(negedge clk);
      end
      if (!disp) begin
        // R10 whole blank line budget
        chk(cpuCnt == 105, "R10 cpu cycles", cpuCnt, 105);
        chk(refCnt == 9, "R10 refresh cycles", refCnt, 9);
      end
      cpuCnt = 0; refCnt = 0;
      v = (v == total - 1) ? 0 : v + 1;
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule